// File: doc/BRIEF.md
# PLL Control and Lock-Status Register Block

This block holds the software-visible configuration of a clock generator built around one main synthesising PLL and two auxiliary fixed-ratio PLLs. A simple single-cycle register bus writes and reads four configuration registers: PLL enables, auto-idle, multiplier/divider select and core clock source. It also reads back a status word and a sticky flag word. The block decodes the stored settings into the signals an external clock tree needs: the effective main-PLL mode, the multiplier, the divider and the core source select.

The analog PLLs are not part of the block, so lock acquisition of the main PLL is modelled by a timer. A one-cycle `ref_tick` strobe marks each reference clock period. A prescaler divides these strobes by (divider + 1) to form the internal comparison rate, and the PLL reports lock after 20 of those internal periods. Any change to a setting that the main PLL depends on drops lock at once and starts the count again. Reset counts as such a change.

Register map (3-bit `addr`): 0 enables, 1 auto-idle, 2 multiplier/divider select, 3 core source, 4 status (read-only), 5 flags (write 1 to clear). Addresses 6 and 7 are unused.

Top module: `pll_ctl_regs`

## Requirements
- R1: The configuration registers reset as follows: enables 0x1, auto-idle 0x0, select 0x0, core source 0x2. A write keeps only the kept bits of each register and reads back masked: enables and auto-idle 0xCF, select 0x03BFFF28, core source 0x3.
- R2: Flag bit 0 (warning) sets when a write to any of addresses 0 to 3 carries a 1 in a bit outside that register's kept mask. The bit stays set until a write of 1 to flag bit 0 clears it.
- R3: The multiplier output is select bits [21:12] and the divider output is select bits [11:8]. The core source output is core source bits [1:0]. The mode output equals enables bits [1:0] (1 low-power bypass, 2 fast-relock bypass, 3 lock, 0 illegal), except that it is forced to 1 when the multiplier is 0 or 1.
- R4: While the effective mode is 3, the main PLL reports locked after exactly 20 × (divider + 1) `ref_tick` pulses counted from the last restart, and not before. In any other mode it reports unlocked.
- R5: A restart happens on a write that changes enables bits [1:0], on a write that changes select bits 0x003FFF00, and on a write that changes core source bits [1:0]. A restart clears lock on the next clock and restarts the count. A write that leaves these bits unchanged, or that targets auto-idle, does not disturb the count.
- R6: The status word reads 0x70 ORed with three fields. Bit 9 is 1 when enables [7:6] equals 3. Bit 8 is 1 when enables [3:2] equals 3. Bits [1:0] read 3 when the core source is 0, otherwise 2 when the main PLL is locked and 1 when it is not.
- R7: Flag bit 1 (error) sets when either of two checks fails. The first runs on a restart-causing write and fails when the new effective mode is 0 or the new core source is 3. The second runs on a write that changes enables bits 0xCC and fails when either auxiliary field becomes 1 or 2. The bit is sticky and is cleared by writing 1 to flag bit 1.
- R8: Writes to the status address and to addresses 6 and 7 change nothing. Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| dpll_mode | output | 2 | Effective main-PLL mode after multiplier forcing |
| dpll_mult | output | 10 | Main-PLL multiplier |
| dpll_div | output | 4 | Main-PLL reference divider |
| core_src | output | 2 | Core clock source select |

## Verification
The bench drives random writes that are weighted towards lock mode, multipliers of 0 and 1, small dividers and occasional reserved bits, followed by random runs of reference ticks. A bench model predicts every register, flag, status word and output, which separates mask errors, wrong forcing of bypass and misplaced status fields. Directed cases pin the lock edge: one tick short of 20 × (divider + 1) must still read unlocked, and the next tick must read locked. Rewriting an identical value, or writing auto-idle, mid-count must not move that edge, while changing the divider must drop lock at once. Illegal modes, illegal auxiliary fields and writes to unused addresses show whether the sticky flags and address decoding tell legal writes from illegal ones.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;

  localparam int DW       = 32;
  localparam int AW       = 3;
  localparam int MULT_LSB = 12;
  localparam int MULT_W   = 10;
  localparam int DIV_LSB  = 8;
  localparam int DIV_W    = 4;

  localparam logic [DW-1:0] EN_KEEP    = 32'h0000_00CF;
  localparam logic [DW-1:0] IDLE_KEEP  = 32'h0000_00CF;
  localparam logic [DW-1:0] SEL_KEEP   = 32'h03BF_FF28;
  localparam logic [DW-1:0] SRC_KEEP   = 32'h0000_0003;
  localparam logic [DW-1:0] EN_AUX_MSK = 32'h0000_00CC;
  localparam logic [DW-1:0] EN_MPL_MSK = 32'h0000_0003;
  localparam logic [DW-1:0] SEL_MPL_MSK = 32'h003F_FF00;
  localparam logic [DW-1:0] STAT_BASE  = 32'h0000_0070;

  localparam logic [DW-1:0] EN_RST   = 32'h0000_0001;
  localparam logic [DW-1:0] IDLE_RST = 32'h0000_0000;
  localparam logic [DW-1:0] SEL_RST  = 32'h0000_0000;
  localparam logic [DW-1:0] SRC_RST  = 32'h0000_0002;

  typedef enum logic [AW-1:0] {
    A_EN   = 3'd0,
    A_IDLE = 3'd1,
    A_SEL  = 3'd2,
    A_SRC  = 3'd3,
    A_STAT = 3'd4,
    A_FLAG = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    DM_OFF    = 2'd0,
    DM_LP_BYP = 2'd1,
    DM_FR_BYP = 2'd2,
    DM_LOCK   = 2'd3
  } mpll_mode_e;

  // effective main-PLL mode: small multipliers force low-power bypass
  function automatic logic [1:0] fx_eff_mode(input logic [1:0] fld,
                                             input logic [MULT_W-1:0] mult);
    return (mult < MULT_W'(2)) ? DM_LP_BYP : fld;
  endfunction

  function automatic logic fx_aux_locked(input logic [1:0] fld);
    return fld == 2'b11;
  endfunction

  function automatic logic fx_aux_bad(input logic [1:0] fld);
    return (fld == 2'b01) || (fld == 2'b10);
  endfunction

  function automatic logic [1:0] fx_src_code(input logic [1:0] src, input logic locked);
    if (src == 2'd0) return 2'd3;
    return locked ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/pll_reg_file.sv
module pll_reg_file import pll_ctl_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] idle_q,
  output logic [DW-1:0] sel_q,
  output logic [DW-1:0] src_q,
  output logic          mpll_reeval,
  output logic          aux_reeval,
  output logic          rsvd_hit,
  output logic          illegal_hit
);

  logic hit_en, hit_idle, hit_sel, hit_src;
  logic [DW-1:0] en_nx, sel_nx, src_nx;
  logic [1:0]    nx_mode;

  always_comb begin
    hit_en   = wr_en && (wr_addr == A_EN);
    hit_idle = wr_en && (wr_addr == A_IDLE);
    hit_sel  = wr_en && (wr_addr == A_SEL);
    hit_src  = wr_en && (wr_addr == A_SRC);

    en_nx  = hit_en  ? (wdata & EN_KEEP)  : en_q;
    sel_nx = hit_sel ? (wdata & SEL_KEEP) : sel_q;
    src_nx = hit_src ? (wdata & SRC_KEEP) : src_q;

    aux_reeval  = hit_en && (((en_q ^ wdata) & EN_AUX_MSK) != '0);
    mpll_reeval = (hit_en  && (((en_q  ^ wdata) & EN_MPL_MSK)  != '0)) ||
                  (hit_sel && (((sel_q ^ wdata) & SEL_MPL_MSK) != '0)) ||
                  (hit_src && (((src_q ^ wdata) & SRC_KEEP)    != '0));

    rsvd_hit = (hit_en   && ((wdata & ~EN_KEEP)   != '0)) ||
               (hit_idle && ((wdata & ~IDLE_KEEP) != '0)) ||
               (hit_sel  && ((wdata & ~SEL_KEEP)  != '0)) ||
               (hit_src  && ((wdata & ~SRC_KEEP)  != '0));

    nx_mode = fx_eff_mode(en_nx[1:0], sel_nx[MULT_LSB +: MULT_W]);
    illegal_hit = (mpll_reeval && ((nx_mode == DM_OFF) || (src_nx[1:0] == 2'd3))) ||
                  (aux_reeval  && (fx_aux_bad(en_nx[7:6]) || fx_aux_bad(en_nx[3:2])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= EN_RST;
      idle_q <= IDLE_RST;
      sel_q  <= SEL_RST;
      src_q  <= SRC_RST;
    end else begin
      en_q  <= en_nx;
      sel_q <= sel_nx;
      src_q <= src_nx;
      if (hit_idle) idle_q <= wdata & IDLE_KEEP;
    end
  end

  AST_IDLE_NO_REEVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_IDLE)) |-> !(mpll_reeval || aux_reeval)); // R5

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int LOCK_CYCLES = 20,
  parameter int DIV_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             lock_mode,
  input  logic [DIV_W-1:0] div,
  input  logic             ref_tick,
  output logic             locked
);

  localparam int CW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;

  logic [DIV_W-1:0] pre_q;
  logic [CW-1:0]    cnt_q;
  logic             int_tick;

  // one internal reference period completes on this strobe
  assign int_tick = ref_tick && (pre_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      locked <= 1'b0;
    end else if (restart || !lock_mode) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      locked <= 1'b0;
    end else if (ref_tick && !locked) begin
      if (int_tick) begin
        pre_q <= '0;
        if (cnt_q == CW'(LOCK_CYCLES - 1)) locked <= 1'b1;
        else cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  AST_RESTART_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !locked); // R5
  AST_LOCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_tick)); // R4
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !restart && lock_mode) |=> locked); // R4
  AST_LOCK_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> lock_mode); // R4

endmodule

// File: rtl/pll_flag_regs.sv
module pll_flag_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       warn_set,
  input  logic       err_set,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,
  output logic       warn,
  output logic       err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (warn_set) warn <= 1'b1;
      else if (clr_wr && clr_bits[0]) warn <= 1'b0;
      if (err_set) err <= 1'b1;
      else if (clr_wr && clr_bits[1]) err <= 1'b0;
    end
  end

  AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (warn && !(clr_wr && clr_bits[0])) |=> warn); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(clr_wr && clr_bits[1])) |=> err); // R7
  AST_WARN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    warn_set |=> warn); // R2

endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs import pll_ctl_pkg::*; #(
  parameter int LOCK_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              ref_tick,
  output logic [1:0]        dpll_mode,
  output logic [MULT_W-1:0] dpll_mult,
  output logic [DIV_W-1:0]  dpll_div,
  output logic [1:0]        core_src
);

  logic [DW-1:0] en_q, idle_q, sel_q, src_q;
  logic          mpll_reeval, aux_reeval, rsvd_hit, illegal_hit;
  logic          mpll_locked, warn, err;
  logic [DW-1:0] stat_word;

  pll_reg_file u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (addr),
    .wdata       (wdata),
    .en_q        (en_q),
    .idle_q      (idle_q),
    .sel_q       (sel_q),
    .src_q       (src_q),
    .mpll_reeval (mpll_reeval),
    .aux_reeval  (aux_reeval),
    .rsvd_hit    (rsvd_hit),
    .illegal_hit (illegal_hit)
  );

  assign dpll_mult = sel_q[MULT_LSB +: MULT_W];
  assign dpll_div  = sel_q[DIV_LSB +: DIV_W];
  assign core_src  = src_q[1:0];
  assign dpll_mode = fx_eff_mode(en_q[1:0], dpll_mult);

  pll_lock_timer #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .DIV_W       (DIV_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (mpll_reeval),
    .lock_mode (dpll_mode == DM_LOCK),
    .div       (dpll_div),
    .ref_tick  (ref_tick),
    .locked    (mpll_locked)
  );

  pll_flag_regs u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .warn_set (rsvd_hit),
    .err_set  (illegal_hit),
    .clr_wr   (wr_en && (addr == A_FLAG)),
    .clr_bits (wdata[1:0]),
    .warn     (warn),
    .err      (err)
  );

  always_comb begin
    stat_word = STAT_BASE;
    stat_word[9]   = fx_aux_locked(en_q[7:6]);
    stat_word[8]   = fx_aux_locked(en_q[3:2]);
    stat_word[1:0] = fx_src_code(core_src, mpll_locked);
  end

  always_comb begin
    case (addr)
      A_EN:    rdata = en_q;
      A_IDLE:  rdata = idle_q;
      A_SEL:   rdata = sel_q;
      A_SRC:   rdata = src_q;
      A_STAT:  rdata = stat_word;
      A_FLAG:  rdata = {{(DW-2){1'b0}}, err, warn};
      default: rdata = '0;
    endcase
  end

  AST_BYPASS_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (dpll_mode != DM_LOCK) |-> !mpll_locked); // R4
  AST_SRC32K_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_STAT && core_src == 2'd0) |-> (rdata[1:0] == 2'd3)); // R6

endmodule

// File: tb/sim_pll_ctl_regs.sv
module sim_pll_ctl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ref_tick = 1'b0;
  logic [1:0]  dpll_mode;
  logic [9:0]  dpll_mult;
  logic [3:0]  dpll_div;
  logic [1:0]  core_src;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model
  logic [31:0] m_en, m_idle, m_sel, m_src;
  bit          m_warn, m_err;
  int          m_ticks;

  always #5 clk = ~clk;

  pll_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ref_tick(ref_tick), .dpll_mode(dpll_mode),
    .dpll_mult(dpll_mult), .dpll_div(dpll_div), .core_src(core_src)
  );

  function automatic logic [1:0] f_mode(input logic [31:0] en, input logic [31:0] sel);
    int mult;
    mult = int'((sel >> 12) & 32'h3FF);
    if (mult <= 1) return 2'd1;
    return en[1:0];
  endfunction

  function automatic bit f_locked();
    int need;
    need = 20 * (int'((m_sel >> 8) & 32'hF) + 1);
    return (f_mode(m_en, m_sel) == 2'd3) && (m_ticks >= need);
  endfunction

  function automatic logic [31:0] f_status();
    logic [31:0] s;
    s = 32'h70;
    if (m_en[7:6] == 2'b11) s = s | 32'h200;
    if (m_en[3:2] == 2'b11) s = s | 32'h100;
    if (m_src[1:0] == 2'd0) s = s | 32'h3;
    else if (f_locked()) s = s | 32'h2;
    else s = s | 32'h1;
    return s;
  endfunction

  function automatic bit f_auxbad(input logic [1:0] f);
    return f == 2'd1 || f == 2'd2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b0;
    addr  = a;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] old;
    bit mch, ach;
    mch = 0; ach = 0;
    case (a)
      3'd0: begin
        if ((d & ~32'hCF) != 0) m_warn = 1;
        ach = ((m_en ^ d) & 32'hCC) != 0;
        mch = ((m_en ^ d) & 32'h3) != 0;
        m_en = d & 32'hCF;
      end
      3'd1: begin
        if ((d & ~32'hCF) != 0) m_warn = 1;
        m_idle = d & 32'hCF;
      end
      3'd2: begin
        if ((d & ~32'h03BFFF28) != 0) m_warn = 1;
        old = m_sel;
        mch = ((old ^ d) & 32'h003FFF00) != 0;
        m_sel = d & 32'h03BFFF28;
      end
      3'd3: begin
        if ((d & ~32'h3) != 0) m_warn = 1;
        mch = ((m_src ^ d) & 32'h3) != 0;
        m_src = d & 32'h3;
      end
      3'd5: begin
        if (d[0]) m_warn = 0;
        if (d[1]) m_err = 0;
      end
      default: ;
    endcase
    if (mch) begin
      m_ticks = 0;
      if (f_mode(m_en, m_sel) == 2'd0 || m_src[1:0] == 2'd3) m_err = 1;
    end
    if (ach && (f_auxbad(m_en[7:6]) || f_auxbad(m_en[3:2]))) m_err = 1;
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
    m_ticks += n;
  endtask

  task automatic check_all();
    logic [31:0] d;
    rd(3'd0, d); chk("R1 enables", d, m_en);
    rd(3'd1, d); chk("R1 auto-idle", d, m_idle);
    rd(3'd2, d); chk("R1 select", d, m_sel);
    rd(3'd3, d); chk("R1 core source", d, m_src);
    rd(3'd4, d); chk("R6 status", d, f_status());
    rd(3'd5, d); chk("R2 warn flag", {31'b0, d[0]}, {31'b0, m_warn});
    chk("R7 error flag", {31'b0, d[1]}, {31'b0, m_err});
    chk("R3 mode out", {30'b0, dpll_mode}, {30'b0, f_mode(m_en, m_sel)});
    chk("R3 mult out", {22'b0, dpll_mult}, (m_sel >> 12) & 32'h3FF);
    chk("R3 div out", {28'b0, dpll_div}, (m_sel >> 8) & 32'hF);
    chk("R3 core out", {30'b0, core_src}, m_src & 32'h3);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    int rs;
    rs = $urandom(32'd20240611);
    m_en = 32'h1; m_idle = 0; m_sel = 0; m_src = 32'h2;
    m_warn = 0; m_err = 0; m_ticks = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_all();
    rd(3'd4, d); chk("R6 reset status", d, 32'h71);

    // R1 masks, R2 warning, R6 aux locks
    wr(3'd0, 32'hFFFF_FFFF); check_all();
    rd(3'd0, d); chk("R1 enable mask", d, 32'hCF);
    rd(3'd5, d); chk("R2 warn after reserved write", d & 32'h1, 32'h1);
    rd(3'd4, d); chk("R6 aux lock bits", d & 32'h300, 32'h300);
    wr(3'd5, 32'h1); rd(3'd5, d); chk("R2 warn cleared", d & 32'h1, 32'h0);

    // R3 forced bypass with multiplier 1
    wr(3'd2, (32'd1 << 12) | (32'd2 << 8));
    chk("R3 forced bypass", {30'b0, dpll_mode}, 32'd1);

    // R4 lock boundary with divider 2 -> 60 ticks
    wr(3'd2, (32'd100 << 12) | (32'd2 << 8));
    wr(3'd3, 32'h1);
    wr(3'd0, 32'h3);
    check_all();
    ticks(30);
    wr(3'd0, 32'h3);            // same value: R5 no restart
    wr(3'd1, 32'h41);           // auto-idle: R5 no restart
    ticks(29);
    rd(3'd4, d); chk("R4 one tick short", d & 32'h3, 32'h1);
    ticks(1);
    rd(3'd4, d); chk("R4 locked at boundary", d & 32'h3, 32'h2);
    chk("R5 rewrite kept count", {31'b0, f_locked()}, 32'h1);
    check_all();

    // R6 core on 32 kHz, then R5 restart on divider change
    wr(3'd3, 32'h0); rd(3'd4, d); chk("R6 32k code", d & 32'h3, 32'h3);
    wr(3'd3, 32'h2); ticks(60);
    wr(3'd2, (32'd100 << 12) | (32'd3 << 8));
    rd(3'd4, d); chk("R5 divider change drops lock", d & 32'h3, 32'h1);
    check_all();

    // R7 illegal main mode and aux field
    wr(3'd0, 32'h0); rd(3'd5, d); chk("R7 error on mode 0", d & 32'h2, 32'h2);
    wr(3'd5, 32'h2); rd(3'd5, d); chk("R7 error cleared", d & 32'h2, 32'h0);
    wr(3'd0, 32'h41); rd(3'd5, d); chk("R7 error on aux field 1", d & 32'h2, 32'h2);
    wr(3'd5, 32'h3);
    check_all();

    // R8 unused and read-only addresses
    wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'h1234_5678); wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd6, d); chk("R8 addr 6 reads 0", d, 32'h0);
    rd(3'd7, d); chk("R8 addr 7 reads 0", d, 32'h0);
    check_all();

    // random phase
    for (int it = 0; it < 300; it++) begin
      int r;
      logic [31:0] v;
      r = $urandom % 10;
      if (r < 3) begin
        v = $urandom & 32'hCF;
        if ($urandom % 3 == 0) v[1:0] = 2'd3;
        if ($urandom % 10 == 0) v = v | 32'h30;
        wr(3'd0, v);
      end else if (r == 3) begin
        v = $urandom;
        if ($urandom % 2 == 0) v = v & 32'hCF;
        wr(3'd1, v);
      end else if (r < 7) begin
        int mult, dv;
        mult = ($urandom % 5 == 0) ? ($urandom % 2) : ($urandom % 1024);
        dv = ($urandom % 6 == 0) ? ($urandom % 16) : ($urandom % 4);
        v = (32'(mult) << 12) | (32'(dv) << 8) | ($urandom & 32'h0380_0028);
        if ($urandom % 10 == 0) v = v | 32'h40;
        wr(3'd2, v);
      end else if (r < 9) begin
        v = $urandom % 4;
        if ($urandom % 10 == 0) v = v | 32'h10;
        wr(3'd3, v);
      end else begin
        wr(3'd5, $urandom % 4);
      end
      ticks($urandom % 90);
      check_all();
    end

    done = 1;
    finish_run();
  end

endmodule